// File: doc/BRIEF.md
# Register-Mapped Iterative Divider

This block is an unsigned 32-by-32 divider that software drives through a small 16-bit register port. Software first writes a control value that selects division, then loads the dividend into register pair A and the divisor into register pair B, one 16-bit half at a time and in any order. A further control write with the start bit set launches the operation.

The engine retires two quotient bits per clock through two cascaded restoring subtract stages, so a full 32-bit result takes 16 clocks. The quotient is shifted into register pair A in place of the dividend. The remainder builds up in register pair C. When the last step retires, hardware clears the start bit and raises a one-clock interrupt pulse. Software can either wait for that pulse or poll the start bit.

Top module: `mdiv_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0x0000 and `irq` is low.
- R2: Register offsets on `bus_addr`: 0 control, 1 A low half, 2 A high half, 3 B low half, 4 B high half, 5 C low half, 6 C high half. Each data half holds bits [15:0] or [31:16] of its 32-bit pair. Register pair C is read-only.
- R3: A control write with bit 7 (mode) and bit 0 (start) both set, made while idle, starts a division. Control bit 0 then reads 1 for the 16 clocks that follow the write edge and reads 0 from the 16th edge on.
- R4: `irq` is high for exactly one clock, starting at the edge where control bit 0 clears.
- R5: On completion, pair A holds the 32-bit quotient, pair C holds the remainder, and pair B still holds the divisor.
- R6: With a zero divisor, the quotient is 0xFFFFFFFF, the remainder equals the dividend, and the unit completes on the normal schedule.
- R7: A control write with bit 0 set but bit 7 clear starts nothing. Control reads 0x0000, `irq` stays low, and pair A is unchanged.
- R8: While a division is running, writes to any register are ignored, including a second start.
- R9: For a nonzero divisor, the completed remainder is less than the divisor.
- R10: `bus_rdata` shows the register addressed by `bus_addr` one clock after the address is presented. The control word reads with bit 7 = mode, bit 0 = busy and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Division-complete pulse |

## Verification
The bench goes after divisor zero. A design that guards it badly either hangs or returns a remainder of zero instead of the dividend. It also targets dividends with the top bit set and the all-ones operands, where a trial subtract one bit too narrow corrupts the quotient's upper bits. The start bit is sampled on every one of the 17 cycles after launch, and the interrupt is checked for its single-cycle width, which exposes an off-by-one in the step counter. Writes issued mid-run, and a start issued without the mode bit, show whether a design lets either one disturb the operands or the result.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
  localparam int ADDR_W    = 3;
  localparam int MODE_BIT  = 7;
  localparam int START_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_A_LO = 3'd1,
    REG_A_HI = 3'd2,
    REG_B_LO = 3'd3,
    REG_B_HI = 3'd4,
    REG_C_LO = 3'd5,
    REG_C_HI = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/mdiv_step.sv
module mdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] num_in,
  input  logic [W-1:0] den,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] num_out
);
  logic [W:0]   trial;
  logic [W-1:0] diff;
  logic         fits;

  always_comb begin
    trial   = {rem_in, num_in[W-1]};
    fits    = (trial >= {1'b0, den});
    diff    = trial[W-1:0] - den;
    rem_out = fits ? diff : trial[W-1:0];
    num_out = {num_in[W-2:0], fits};
  end
endmodule

// File: rtl/mdiv_datapath.sv
module mdiv_datapath #(
  parameter int W    = 32,
  parameter int BITS = 2
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] num_in,
  input  logic [W-1:0] den,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] num_out
);
  logic [W-1:0] rem_c [BITS+1];
  logic [W-1:0] num_c [BITS+1];

  assign rem_c[0] = rem_in;
  assign num_c[0] = num_in;

  for (genvar s = 0; s < BITS; s++) begin : g_stage
    mdiv_step #(.W(W)) u_step (
      .rem_in (rem_c[s]),
      .num_in (num_c[s]),
      .den    (den),
      .rem_out(rem_c[s+1]),
      .num_out(num_c[s+1])
    );
  end

  assign rem_out = rem_c[BITS];
  assign num_out = num_c[BITS];
endmodule

// File: rtl/mdiv_sequencer.sv
module mdiv_sequencer #(
  parameter int ITER = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic irq
);
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;

  logic [CNT_W-1:0] step_q;
  logic             last;

  assign last = busy && (step_q == CNT_W'(ITER - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      irq    <= 1'b0;
      step_q <= '0;
    end else begin
      irq <= last;
      if (start) begin
        busy   <= 1'b1;
        step_q <= '0;
      end else if (busy) begin
        step_q <= step_q + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  // run-length counter used only by the checks below
  logic [CNT_W:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  assert_run_len_R3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (run_cnt == (CNT_W+1)'(ITER)));

  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_at_clear_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy)));
endmodule

// File: rtl/mdiv_unit.sv
module mdiv_unit #(
  parameter int BUS_W      = 16,
  parameter int RADIX_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [mdiv_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       bus_wr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  output logic                       irq
);
  import mdiv_pkg::*;

  localparam int DATA_W = 2 * BUS_W;
  localparam int ITER   = DATA_W / RADIX_BITS;

  initial begin
    if (DATA_W % RADIX_BITS != 0)
      $error("RADIX_BITS must divide the operand width");
  end

  logic [DATA_W-1:0] a_q, b_q, c_q;
  logic              mode_q;
  logic              busy;
  logic              start_req;
  logic [DATA_W-1:0] nxt_rem, nxt_num;

  assign start_req = bus_wr && !busy && (bus_addr == REG_CTRL)
                     && bus_wdata[MODE_BIT] && bus_wdata[START_BIT];

  mdiv_sequencer #(.ITER(ITER)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start_req),
    .busy (busy),
    .irq  (irq)
  );

  mdiv_datapath #(.W(DATA_W), .BITS(RADIX_BITS)) u_dp (
    .rem_in (c_q),
    .num_in (a_q),
    .den    (b_q),
    .rem_out(nxt_rem),
    .num_out(nxt_num)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      mode_q <= 1'b0;
    end else if (busy) begin
      a_q <= nxt_num;
      c_q <= nxt_rem;
    end else if (bus_wr) begin
      case (bus_addr)
        REG_CTRL: begin
          mode_q <= bus_wdata[MODE_BIT];
          if (start_req) c_q <= '0;
        end
        REG_A_LO: a_q[BUS_W-1:0]      <= bus_wdata;
        REG_A_HI: a_q[DATA_W-1:BUS_W] <= bus_wdata;
        REG_B_LO: b_q[BUS_W-1:0]      <= bus_wdata;
        REG_B_HI: b_q[DATA_W-1:BUS_W] <= bus_wdata;
        default: ;
      endcase
    end
  end

  logic [BUS_W-1:0] ctrl_word;
  always_comb begin
    ctrl_word            = '0;
    ctrl_word[MODE_BIT]  = mode_q;
    ctrl_word[START_BIT] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        REG_CTRL: bus_rdata <= ctrl_word;
        REG_A_LO: bus_rdata <= a_q[BUS_W-1:0];
        REG_A_HI: bus_rdata <= a_q[DATA_W-1:BUS_W];
        REG_B_LO: bus_rdata <= b_q[BUS_W-1:0];
        REG_B_HI: bus_rdata <= b_q[DATA_W-1:BUS_W];
        REG_C_LO: bus_rdata <= c_q[BUS_W-1:0];
        REG_C_HI: bus_rdata <= c_q[DATA_W-1:BUS_W];
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (a_q == '0 && b_q == '0 && c_q == '0 && !mode_q && !irq && !busy));

  assert_b_held_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(b_q));

  assert_dbz_all_ones_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && b_q == '0) |-> (&a_q));

  assert_rem_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && b_q != '0) |-> (c_q < b_q));
endmodule

// File: tb/mdiv_unit_test.sv
module mdiv_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mdiv_unit uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam int NV = 8;
  // dividend, divisor, quotient, remainder
  localparam logic [31:0] VEC [NV][4] = '{
    '{32'd100,        32'd7,          32'd14,         32'd2},
    '{32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
    '{32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1,          32'd0},
    '{32'd5,          32'd10,         32'd0,          32'd5},
    '{32'h80000000,   32'd3,          32'h2AAAAAAA,   32'd2},
    '{32'h12345678,   32'h00010000,   32'h00001234,   32'h00005678},
    '{32'h000F4240,   32'h000003E8,   32'h000003E8,   32'd0},
    '{32'hDEADBEEF,   32'h00000010,   32'h0DEADBEE,   32'h0000000F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd32(input logic [2:0] lo, output logic [31:0] v);
    logic [15:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic load(input logic [31:0] dvd, input logic [31:0] dvs);
    wr(3'd4, dvs[31:16]);
    wr(3'd1, dvd[15:0]);
    wr(3'd3, dvs[15:0]);
    wr(3'd2, dvd[31:16]);
    wr(3'd0, 16'h0080);
  endtask

  // start and follow the 17 cycles after the start edge
  task automatic start_and_track(input string tag);
    wr(3'd0, 16'h0081);
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk);
      chk({tag, " R4 irq timing"}, {31'd0, irq}, (k == 16) ? 32'd1 : 32'd0);
      chk({tag, " R3 busy bit"}, {31'd0, bus_rdata[0]}, (k <= 16) ? 32'd1 : 32'd0);
    end
  endtask

  initial begin
    logic [15:0] d16;
    logic [31:0] q, r, b;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d16);
      chk("R1 reg", {16'd0, d16}, 32'd0);
    end

    // R2 / R10: half placement and read latency
    wr(3'd1, 16'hBEEF);
    wr(3'd2, 16'hDEAD);
    rd32(3'd1, q);
    chk("R2 A pair readback", q, 32'hDEADBEEF);
    wr(3'd0, 16'h0080);
    rd(3'd0, d16);
    chk("R10 control word", {16'd0, d16}, 32'h0080);

    // R3 R4 R5 R9: vector table
    for (int i = 0; i < NV; i++) begin
      load(VEC[i][0], VEC[i][1]);
      start_and_track("vec");
      rd32(3'd1, q);
      rd32(3'd5, r);
      rd32(3'd3, b);
      chk("R5 quotient", q, VEC[i][2]);
      chk("R5 remainder", r, VEC[i][3]);
      chk("R5 divisor kept", b, VEC[i][1]);
      chk("R9 remainder below divisor", {31'd0, r < b}, 32'd1);
      chk("R9 reconstruct", q * b + r, VEC[i][0]);
    end

    // R6: divide by zero
    load(32'h13579BDF, 32'd0);
    start_and_track("dbz R6");
    rd32(3'd1, q);
    rd32(3'd5, r);
    chk("R6 quotient all ones", q, 32'hFFFFFFFF);
    chk("R6 remainder is dividend", r, 32'h13579BDF);

    // R7: start without mode bit
    load(32'h00001234, 32'd2);
    wr(3'd0, 16'h0001);
    rd(3'd0, d16);
    chk("R7 control reads zero", {16'd0, d16}, 32'd0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R7 no irq", {31'd0, irq}, 32'd0);
    end
    rd32(3'd1, q);
    chk("R7 A unchanged", q, 32'h00001234);

    // R8: writes while busy are ignored
    load(32'd1000, 32'd9);
    wr(3'd0, 16'h0081);
    wr(3'd1, 16'hAAAA);
    wr(3'd3, 16'h5555);
    wr(3'd0, 16'h0081);
    wr(3'd0, 16'h0000);
    begin
      int n = 0;
      while (!irq && n < 40) begin
        @(negedge clk);
        n++;
      end
      chk("R8 completed", {31'd0, irq}, 32'd1);
    end
    @(negedge clk);
    chk("R4 single pulse", {31'd0, irq}, 32'd0);
    rd32(3'd1, q);
    rd32(3'd5, r);
    rd32(3'd3, b);
    chk("R8 quotient", q, 32'd111);
    chk("R8 remainder", r, 32'd1);
    chk("R8 divisor kept", b, 32'd9);
    rd(3'd0, d16);
    chk("R8 control mode kept", {16'd0, d16}, 32'h0080);

    // R2: C pair is read-only
    wr(3'd5, 16'h7777);
    rd32(3'd5, r);
    chk("R2 C read-only", r, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule